// File: doc/BRIEF.md
# Eight-channel AES3 stream receiver and channel demultiplexer

This block takes one single-wire AES3 line that carries eight audio channels, packed as four stereo pairs, and turns it into eight parallel 24-bit sample registers. The line is oversampled by the system clock. The receiver measures the time between line transitions and sorts each interval into a half-bit, full-bit or preamble-length cell. From those cells it recovers the biphase-mark data bits. It also recognises the three subframe preambles.

Each subframe carries a 24-bit sample, sent least significant bit first, followed by the validity, user, channel-status and parity bits. When a subframe passes the parity check, the receiver writes its sample into one of eight channel registers. A slot counter picks the register: the counter returns to zero on the preamble that marks the start of a block and steps forward once per subframe. The downstream mixing logic uses a one-cycle new-data strobe, a block-sync pulse and a link-active flag to follow the stream.

Top module: `aes8_stream_receiver`

## Requirements
- R1: A data bit of 0 is one full-bit interval (about 2×HALF_CLKS clocks) and a data bit of 1 is two half-bit intervals. The first 24 data bits of a subframe form the sample, least significant bit first.
- R2: A preamble is recognised from four consecutive intervals, given in half-bit cells: 3,3,1,1 is the X type, 3,2,1,2 is the Y type and 3,1,1,3 is the Z type.
- R3: An interval of n clocks is classified as follows. It is a half-bit if 2n is below 3×HALF_CLKS, a full bit if 2n is below 5×HALF_CLKS and a long cell if 2n is below 7×HALF_CLKS. An interval below HALF_CLKS/2 clocks, or one past the long range, is invalid. An invalid interval abandons the current subframe, and the receiver resynchronises on the next preamble.
- R4: A Z preamble sets the slot counter to 0. An X or Y preamble advances the counter by one, and after slot NUM_CH-1 it wraps to 0. The slot counter is 0 out of reset.
- R5: `block_sync` is high for exactly one cycle for each Z preamble recognised.
- R6: A subframe counts as good when the 28 bits after its preamble contain an even number of ones. `new_data` is high for exactly one cycle for each good subframe. A subframe that fails parity, or that contains an invalid interval, produces no pulse and writes no register, but it still moves the slot counter.
- R7: On a good subframe, only the channel register selected by the slot counter is updated. Channel g sits in `ch_samples[24g+23:24g]`. All other registers hold their values.
- R8: `sub_flags` holds the status bits of the last good subframe: bit 0 is validity, bit 1 is user, bit 2 is channel status and bit 3 is parity.
- R9: `link_active` rises together with a `new_data` pulse. It falls once no preamble has been recognised for TIMEOUT_SUBFRAMES×64×HALF_CLKS clocks. A recognised preamble alone, without a good subframe, does not raise it.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous biphase-mark line |
| new_data | output | 1 | One-cycle pulse per good subframe |
| block_sync | output | 1 | One-cycle pulse per Z preamble |
| link_active | output | 1 | Stream currently delivering good subframes |
| sub_flags | output | 4 | Validity, user, channel-status, parity of last good subframe |
| ch_samples | output | NUM_CH×24 (192) | Per-channel sample registers, channel 0 lowest |

## Verification
The bench builds the receiver with HALF_CLKS=4, NUM_CH=8 and TIMEOUT_SUBFRAMES=4. With these values a subframe lasts 256 clocks and the silence timeout is 1024 clocks, so complete blocks, counter wraps without a Z preamble, and the loss and recovery of the link all fit in a short run. At this small cell size a ±1 clock jitter moves each interval close to the edges of its classification band. The bench sweeps every slot under several sample patterns, every combination of status bits, parity failures, over-long cells and one-clock glitches.

// File: rtl/aes8_rx_pkg.sv
package aes8_rx_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int FLAG_W     = 4;
    localparam int FRAME_BITS = SAMPLE_W + FLAG_W;
    localparam int SUBFRAME_HALVES = 64;

    typedef enum logic [1:0] {
        CELL_BAD   = 2'd0,
        CELL_SHORT = 2'd1,
        CELL_MED   = 2'd2,
        CELL_LONG  = 2'd3
    } cell_e;

    typedef enum logic [1:0] {
        PRE_X = 2'd0,
        PRE_Y = 2'd1,
        PRE_Z = 2'd2,
        PRE_NONE = 2'd3
    } pre_e;

    typedef struct packed {
        logic [FLAG_W-1:0]   flags;
        logic [SAMPLE_W-1:0] sample;
    } capture_t;

    // Sort an interval of n clocks by comparing 2n to odd multiples of the half cell.
    function automatic cell_e classify(input int unsigned n, input int unsigned half);
        if (2 * n < half)          return CELL_BAD;
        else if (2 * n < 3 * half) return CELL_SHORT;
        else if (2 * n < 5 * half) return CELL_MED;
        else if (2 * n < 7 * half) return CELL_LONG;
        else                       return CELL_BAD;
    endfunction

    // Fourth interval that closes each preamble type.
    function automatic cell_e closing_cell(input pre_e kind);
        case (kind)
            PRE_X:   return CELL_SHORT;
            PRE_Y:   return CELL_MED;
            PRE_Z:   return CELL_LONG;
            default: return CELL_BAD;
        endcase
    endfunction

endpackage

// File: rtl/aes8_cell_timer.sv
module aes8_cell_timer
    import aes8_rx_pkg::*;
#(
    parameter int HALF_CLKS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line_in,
    output logic  cell_stb,
    output cell_e cell_kind
);
    localparam int CNT_MAX = 4 * HALF_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [2:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             edge_seen;

    assign edge_seen = sync_q[2] ^ sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], line_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= CNT_W'(CNT_MAX);
            cell_stb  <= 1'b0;
            cell_kind <= CELL_BAD;
        end else begin
            cell_stb <= edge_seen;
            if (edge_seen) begin
                cell_kind <= classify(32'(cnt_q), HALF_CLKS);
                cnt_q     <= CNT_W'(1);
            end else if (cnt_q != CNT_W'(CNT_MAX)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/aes8_subframe_decoder.sv
module aes8_subframe_decoder
    import aes8_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cell_stb,
    input  cell_e    cell_kind,
    output logic     pre_stb,
    output pre_e     pre_kind,
    output logic     cap_stb,
    output capture_t cap
);
    localparam int BC_W = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_HUNT, ST_PRE1, ST_PRE2, ST_PRE3, ST_BIT, ST_BIT_HALF
    } dec_state_e;

    dec_state_e          state_q;
    pre_e                ptype_q;
    logic [BC_W-1:0]     bitcnt_q;
    logic [FRAME_BITS-1:0] sr_q;
    logic [FRAME_BITS-1:0] sr_zero, sr_one;
    logic                last_bit;
    dec_state_e          resync_state;

    always_comb begin
        sr_zero      = {1'b0, sr_q[FRAME_BITS-1:1]};
        sr_one       = {1'b1, sr_q[FRAME_BITS-1:1]};
        last_bit     = (bitcnt_q == BC_W'(FRAME_BITS - 1));
        resync_state = (cell_kind == CELL_LONG) ? ST_PRE1 : ST_HUNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HUNT;
            ptype_q  <= PRE_NONE;
            bitcnt_q <= '0;
            sr_q     <= '0;
            pre_stb  <= 1'b0;
            pre_kind <= PRE_NONE;
            cap_stb  <= 1'b0;
            cap      <= '0;
        end else begin
            pre_stb <= 1'b0;
            cap_stb <= 1'b0;
            if (cell_stb) begin
                case (state_q)
                    ST_HUNT: begin
                        if (cell_kind == CELL_LONG) state_q <= ST_PRE1;
                    end
                    ST_PRE1: begin
                        state_q <= ST_PRE2;
                        case (cell_kind)
                            CELL_LONG:  ptype_q <= PRE_X;
                            CELL_MED:   ptype_q <= PRE_Y;
                            CELL_SHORT: ptype_q <= PRE_Z;
                            default:    state_q <= ST_HUNT;
                        endcase
                    end
                    ST_PRE2: begin
                        state_q <= (cell_kind == CELL_SHORT) ? ST_PRE3 : resync_state;
                    end
                    ST_PRE3: begin
                        if (cell_kind == closing_cell(ptype_q)) begin
                            pre_stb  <= 1'b1;
                            pre_kind <= ptype_q;
                            bitcnt_q <= '0;
                            state_q  <= ST_BIT;
                        end else begin
                            state_q <= resync_state;
                        end
                    end
                    ST_BIT: begin
                        if (cell_kind == CELL_MED) begin
                            sr_q <= sr_zero;
                            if (last_bit) begin
                                state_q <= ST_HUNT;
                                if (^sr_zero == 1'b0) begin
                                    cap_stb <= 1'b1;
                                    cap     <= capture_t'(sr_zero);
                                end
                            end else begin
                                bitcnt_q <= bitcnt_q + BC_W'(1);
                            end
                        end else if (cell_kind == CELL_SHORT) begin
                            state_q <= ST_BIT_HALF;
                        end else begin
                            state_q <= resync_state;
                        end
                    end
                    ST_BIT_HALF: begin
                        if (cell_kind == CELL_SHORT) begin
                            sr_q <= sr_one;
                            if (last_bit) begin
                                state_q <= ST_HUNT;
                                if (^sr_one == 1'b0) begin
                                    cap_stb <= 1'b1;
                                    cap     <= capture_t'(sr_one);
                                end
                            end else begin
                                bitcnt_q <= bitcnt_q + BC_W'(1);
                                state_q  <= ST_BIT;
                            end
                        end else begin
                            state_q <= resync_state;
                        end
                    end
                    default: state_q <= ST_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/aes8_slot_demux.sv
module aes8_slot_demux
    import aes8_rx_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pre_stb,
    input  pre_e                       pre_kind,
    input  logic                       cap_stb,
    input  capture_t                   cap,
    output logic                       new_data,
    output logic                       block_sync,
    output logic [FLAG_W-1:0]          sub_flags,
    output logic [NUM_CH*SAMPLE_W-1:0] ch_samples
);
    localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= '0;
            new_data   <= 1'b0;
            block_sync <= 1'b0;
            sub_flags  <= '0;
        end else begin
            new_data   <= cap_stb;
            block_sync <= pre_stb && (pre_kind == PRE_Z);
            if (pre_stb) begin
                if (pre_kind == PRE_Z || slot_q == SLOT_W'(NUM_CH - 1)) slot_q <= '0;
                else                                                    slot_q <= slot_q + SLOT_W'(1);
            end
            if (cap_stb) sub_flags <= cap.flags;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [SAMPLE_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)                                   word_q <= '0;
            else if (cap_stb && slot_q == SLOT_W'(g))  word_q <= cap.sample;
        end
        assign ch_samples[g*SAMPLE_W +: SAMPLE_W] = word_q;
    end

endmodule

// File: rtl/aes8_link_monitor.sv
module aes8_link_monitor
    import aes8_rx_pkg::*;
#(
    parameter int HALF_CLKS         = 8,
    parameter int TIMEOUT_SUBFRAMES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pre_stb,
    input  logic cap_stb,
    output logic link_active
);
    localparam int LIMIT = TIMEOUT_SUBFRAMES * SUBFRAME_HALVES * HALF_CLKS;
    localparam int TW    = $clog2(LIMIT + 1);

    logic [TW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q     <= '0;
            link_active <= 1'b0;
        end else begin
            if (pre_stb)                       quiet_q <= '0;
            else if (quiet_q != TW'(LIMIT))    quiet_q <= quiet_q + TW'(1);

            if (cap_stb)                       link_active <= 1'b1;
            else if (quiet_q == TW'(LIMIT))    link_active <= 1'b0;
        end
    end

endmodule

// File: rtl/aes8_stream_receiver.sv
module aes8_stream_receiver
    import aes8_rx_pkg::*;
#(
    parameter int HALF_CLKS         = 8,
    parameter int NUM_CH            = 8,
    parameter int TIMEOUT_SUBFRAMES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_in,
    output logic                       new_data,
    output logic                       block_sync,
    output logic                       link_active,
    output logic [FLAG_W-1:0]          sub_flags,
    output logic [NUM_CH*SAMPLE_W-1:0] ch_samples
);
    logic     cell_stb;
    cell_e    cell_kind;
    logic     pre_stb;
    pre_e     pre_kind;
    logic     cap_stb;
    capture_t cap;

    aes8_cell_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .cell_stb  (cell_stb),
        .cell_kind (cell_kind)
    );

    aes8_subframe_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .cell_stb  (cell_stb),
        .cell_kind (cell_kind),
        .pre_stb   (pre_stb),
        .pre_kind  (pre_kind),
        .cap_stb   (cap_stb),
        .cap       (cap)
    );

    aes8_slot_demux #(.NUM_CH(NUM_CH)) u_demux (
        .clk        (clk),
        .rst        (rst),
        .pre_stb    (pre_stb),
        .pre_kind   (pre_kind),
        .cap_stb    (cap_stb),
        .cap        (cap),
        .new_data   (new_data),
        .block_sync (block_sync),
        .sub_flags  (sub_flags),
        .ch_samples (ch_samples)
    );

    aes8_link_monitor #(
        .HALF_CLKS         (HALF_CLKS),
        .TIMEOUT_SUBFRAMES (TIMEOUT_SUBFRAMES)
    ) u_mon (
        .clk         (clk),
        .rst         (rst),
        .pre_stb     (pre_stb),
        .cap_stb     (cap_stb),
        .link_active (link_active)
    );

endmodule

// File: rtl/aes8_stream_receiver_checks.sv
module aes8_stream_receiver_checks #(
    parameter int NUM_CH = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 new_data,
    input logic                 block_sync,
    input logic                 link_active,
    input logic [3:0]           sub_flags,
    input logic [NUM_CH*24-1:0] ch_samples
);
    // R5: block sync is a single-cycle pulse
    a_r5_bsync_single: assert property (@(posedge clk) disable iff (rst)
        block_sync |=> !block_sync);

    // R6: new-data is a single-cycle pulse
    a_r6_nd_single: assert property (@(posedge clk) disable iff (rst)
        new_data |=> !new_data);

    // R9: the link flag only rises alongside a captured sample
    a_r9_active_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(link_active) |-> new_data);

    // R7: channel registers move only with a new-data pulse
    a_r7_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !new_data |-> $stable(ch_samples));

    // R8: status flags move only with a new-data pulse
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !new_data |-> $stable(sub_flags));
endmodule

bind aes8_stream_receiver aes8_stream_receiver_checks #(.NUM_CH(NUM_CH)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .new_data    (new_data),
    .block_sync  (block_sync),
    .link_active (link_active),
    .sub_flags   (sub_flags),
    .ch_samples  (ch_samples)
);

// File: tb/aes8_stream_receiver_bench.sv
`timescale 1ns/1ps
module aes8_stream_receiver_bench;
    localparam int H     = 4;
    localparam int NCH   = 8;
    localparam int TOUT  = 4;
    localparam int LIMIT = TOUT * 64 * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic new_data, block_sync, link_active;
    logic [3:0] sub_flags;
    logic [NCH*24-1:0] ch_samples;

    always #10 clk = ~clk;

    aes8_stream_receiver #(.HALF_CLKS(H), .NUM_CH(NCH), .TIMEOUT_SUBFRAMES(TOUT)) u_aes8_stream_receiver (
        .clk(clk), .rst(rst), .line_in(line_in), .new_data(new_data),
        .block_sync(block_sync), .link_active(link_active),
        .sub_flags(sub_flags), .ch_samples(ch_samples)
    );

    int checks = 0, fails = 0;
    int nd_cnt = 0, bs_cnt = 0;
    int exp_nd = 0, exp_bs = 0, exp_slot = 0;
    logic [23:0] exp_ch [NCH];
    logic [3:0]  got_flags [256];
    logic [3:0]  exp_flags [256];
    bit jit_on = 0;
    int jcnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (new_data) begin
                if (nd_cnt < 256) got_flags[nd_cnt] = sub_flags;
                nd_cnt++;
            end
            if (block_sync) bs_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_clk(input int n);
        line_in = ~line_in;
        repeat (n) @(negedge clk);
    endtask

    task automatic run(input int k);
        int j;
        j = 0;
        if (jit_on) begin
            j = (jcnt % 3) - 1;
            jcnt++;
        end
        run_clk(k * H + j);
    endtask

    // idle gap: gives the last bit its closing edge, then an invalid-length interval
    task automatic tail();
        run_clk(20 * H);
    endtask

    // pt: 0 = X, 1 = Y, 2 = Z; mode: 0 good, 1 bad parity, 2 over-long cell, 3 one-clock glitch
    task automatic send_sub(input int pt, input logic [23:0] s, input logic [2:0] vuc, input int mode);
        logic [27:0] w;
        logic p;
        p = (^{vuc, s}) ^ (mode == 1);
        w = {p, vuc[2], vuc[1], vuc[0], s};
        case (pt)
            0: begin run(3); run(3); run(1); run(1); end
            1: begin run(3); run(2); run(1); run(2); end
            default: begin run(3); run(1); run(1); run(3); end
        endcase
        for (int i = 0; i < 28; i++) begin
            if (i == 10 && mode == 2) run(5);
            if (i == 10 && mode == 3) run_clk(1);
            if (w[i]) begin run(1); run(1); end
            else run(2);
        end
        // model
        if (pt == 2) begin exp_slot = 0; exp_bs++; end
        else exp_slot = (exp_slot + 1) % NCH;
        if (mode == 0) begin
            exp_ch[exp_slot] = s;
            exp_flags[exp_nd] = w[27:24];
            exp_nd++;
        end
    endtask

    function automatic logic [23:0] samp(input int f, input int ch);
        return 24'((f * 32'h1F3D5 + ch * 32'h2B4C1 + 32'h0A0F07) ^ (f << 19));
    endfunction

    task automatic send_frame(input int f, input int bad_a, input int mode_a, input int bad_b, input int mode_b);
        for (int ch = 0; ch < NCH; ch++) begin
            int pt, md;
            pt = (ch == 0) ? 2 : ((ch % 2) ? 1 : 0);
            md = (ch == bad_a) ? mode_a : ((ch == bad_b) ? mode_b : 0);
            send_sub(pt, samp(f, ch), 3'((f + ch) % 8), md);
        end
    endtask

    task automatic check_all(input string tag);
        for (int ch = 0; ch < NCH; ch++)
            chk({"R1/R4/R7 ", tag}, 32'(ch_samples[ch*24 +: 24]), 32'(exp_ch[ch]));
        chk({"R6 new_data count ", tag}, nd_cnt, exp_nd);
        chk({"R5 block_sync count ", tag}, bs_cnt, exp_bs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) exp_ch[ch] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 new_data", new_data, 0);
        chk("R10 block_sync", block_sync, 0);
        chk("R10 link_active", link_active, 0);
        chk("R10 sub_flags", sub_flags, 0);
        chk("R10 ch_samples", 32'(|ch_samples), 0);
        repeat (10 * H) @(negedge clk);

        // R1 R2 plain block
        send_frame(0, -1, 0, -1, 0); tail();
        check_all("frame0");
        chk("R9 active after good data", link_active, 1);

        // R3 timing jitter of +-1 clock on every cell
        jit_on = 1;
        send_frame(1, -1, 0, -1, 0); tail();
        jit_on = 0;
        check_all("frame1 jitter");

        // R6 parity failure on slot 3
        send_frame(2, 3, 1, -1, 0); tail();
        check_all("frame2 parity");

        // R3 over-long cell on slot 5, glitch on slot 6
        send_frame(3, 5, 2, 6, 3); tail();
        check_all("frame3 bad cells");

        // R4 wrap without Z: slots 7 -> 0, 1, 2
        send_sub(1, 24'hC0FFEE, 3'd5, 0);
        send_sub(0, 24'h0BEEF1, 3'd2, 0);
        send_sub(1, 24'h13579B, 3'd7, 0);
        tail();
        check_all("wrap");

        // R4 Z mid-stream returns to slot 0
        send_frame(5, -1, 0, -1, 0); tail();
        check_all("frame5");

        // R1 extreme bit patterns
        send_sub(2, 24'hFFFFFF, 3'd0, 0);
        send_sub(1, 24'h000000, 3'd1, 0);
        send_sub(0, 24'h800001, 3'd2, 0);
        send_sub(1, 24'hAAAAAA, 3'd3, 0);
        send_sub(0, 24'h555555, 3'd4, 0);
        send_sub(1, 24'h7FFFFF, 3'd5, 0);
        send_sub(0, 24'h000001, 3'd6, 0);
        send_sub(1, 24'hFFFFFE, 3'd7, 0);
        tail();
        check_all("patterns");
        chk("R8 flags of last subframe", sub_flags, exp_flags[exp_nd - 1]);

        // R9 timeout
        repeat (LIMIT / 2) @(negedge clk);
        chk("R9 active before timeout", link_active, 1);
        repeat (LIMIT) @(negedge clk);
        chk("R9 active after timeout", link_active, 0);

        // R9 a preamble with failing parity does not raise the link
        send_sub(1, 24'h246801, 3'd1, 1); tail();
        chk("R9 preamble only keeps link low", link_active, 0);
        check_all("bad after timeout");

        send_sub(2, 24'h123456, 3'd6, 0); tail();
        chk("R9 link back after good data", link_active, 1);
        check_all("recovery");

        // R8 status bit log over every good subframe
        for (int i = 0; i < exp_nd && i < 256; i++)
            chk("R8 sub_flags log", got_flags[i], exp_flags[i]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule